// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is an eight-stage parallel-in, serial-out shift register that runs entirely on one free-running system clock. The external shift clock, the clock-inhibit input, the active-low shift/load control and the serial input are first brought into the system clock domain through a two-flop synchroniser. The synchronised shift clock and inhibit are ORed into a single effective shift clock. A shift is taken on each detected rising edge of that OR.

While the load control is low, every stage follows its parallel input. Loading overrides the clock, the inhibit and the serial input. On a shift, the serial input enters the first stage and the contents move one stage toward the output end. The last stage is driven out in both true and complemented form. A debug bus exposes all stages.

Stage 0 is the input end and takes `par_i[0]` on a load. Stage WIDTH-1 is the output end and takes `par_i[WIDTH-1]`. Software is expected to hold `par_i` steady while a load is in progress.

Top module: `piso_gated_shift`

## Requirements
- R1: While rst_ni is low, all stages read 0, q_o reads 0 and qn_o reads 1.
- R2: While shld_ni is low (after synchronisation), stages_o follows par_i, with bit i of par_i in stage i. This holds whatever sclk_i, inh_i and ser_i do, and later changes of par_i are followed.
- R3: With shld_ni high and inh_i low, a low-to-high change of sclk_i shifts the register once. Stage 0 takes ser_i and stage i takes the old stage i-1.
- R4: With shld_ni high and sclk_i low, a low-to-high change of inh_i also shifts the register once, in the same way as R3.
- R5: A rising edge of sclk_i while inh_i is high causes no shift. A rising edge of inh_i while sclk_i is high causes no shift.
- R6: With shld_ni high and no rising edge of (sclk_i OR inh_i), all stages hold, including across falling edges.
- R7: q_o always equals the last stage (stages_o[WIDTH-1]), and qn_o is always its complement.
- R8: Rising edges that occur while a load is active are discarded. If the shift clock stays high as shld_ni returns high, no shift occurs; the next shift needs a new rising edge.
- R9: A shift becomes visible on stages_o on the third system clock edge after the input edge is presented, and not before.
- R10: sclk_i and inh_i rising together produce exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | External shift clock, asynchronous |
| inh_i | input | 1 | Clock inhibit, ORed with sclk_i, asynchronous |
| shld_ni | input | 1 | Low: load parallel data; high: shift mode |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel load data, bit i to stage i |
| q_o | output | 1 | Last stage |
| qn_o | output | 1 | Complement of last stage |
| stages_o | output | WIDTH | All stages, for debug |

## Verification
The hardest case to reach from the ports is a shift clock that is already high when the load control returns high. Here a naive edge detector would see a rising edge that never happened in shift mode. The bench gets there by raising both sclk_i and inh_i during a load, releasing the load while they stay high, and confirming that nothing moves. A separate step checks the exact three-cycle latency: the stages are sampled one cycle before and at the cycle in which the shift should appear. Around this, a sweep over all 256 load patterns shifts in eight serial bits from each one, alternating between the clock and inhibit inputs as the shift source.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;

  localparam int unsigned SYNC_W = 4;  // {ser, shld_n, inh, sclk}
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge
  import piso_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_s_i,
  input  logic      inh_s_i,
  input  logic      shld_ns_i,
  output stage_op_e op_o
);
  logic gate, gate_q;

  assign gate = sclk_s_i | inh_s_i;

  // previous sample tracks during load so stale edges are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate;
  end

  always_comb begin
    if (!shld_ns_i)          op_o = OP_LOAD;
    else if (gate && !gate_q) op_o = OP_SHIFT;
    else                     op_o = OP_HOLD;
  end
endmodule

// File: rtl/piso_stages.sv
module piso_stages
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stage_op_e        op_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] stages_o
);
  logic [WIDTH-1:0] stg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic shift_in;
    if (i == 0) begin : g_head
      assign shift_in = ser_i;
    end else begin : g_body
      assign shift_in = stg[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= 1'b0;
      else begin
        unique case (op_i)
          OP_LOAD:  stg[i] <= par_i[i];
          OP_SHIFT: stg[i] <= shift_in;
          default:  stg[i] <= stg[i];
        endcase
      end
    end
  end

  assign stages_o = stg;
endmodule

// File: rtl/piso_gated_shift.sv
module piso_gated_shift
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             inh_i,
  input  logic             shld_ni,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             q_o,
  output logic             qn_o,
  output logic [WIDTH-1:0] stages_o
);
  localparam logic [SYNC_W-1:0] SYNC_RST = 4'b0100;  // shift mode, clocks low

  logic [SYNC_W-1:0] raw, synced;
  logic sclk_s, inh_s, shld_ns, ser_s;
  stage_op_e op;

  assign raw = {ser_i, shld_ni, inh_i, sclk_i};

  piso_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {ser_s, shld_ns, inh_s, sclk_s} = synced;

  piso_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .inh_s_i  (inh_s),
    .shld_ns_i(shld_ns),
    .op_o     (op)
  );

  piso_stages #(.WIDTH(WIDTH)) u_stages (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .ser_i   (ser_s),
    .par_i   (par_i),
    .stages_o(stages_o)
  );

  assign q_o  = stages_o[WIDTH-1];
  assign qn_o = ~stages_o[WIDTH-1];
endmodule

module piso_gated_shift_chk
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input stage_op_e        op_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] stages_i,
  input logic             q_i,
  input logic             qn_i
);
  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> stages_i == $past(par_i));

  // R3
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SHIFT |=> stages_i == {$past(stages_i[WIDTH-2:0]), $past(ser_i)});

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(stages_i));

  // R10
  single_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SHIFT |=> op_i != OP_SHIFT);

  // R7
  compl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_i == stages_i[WIDTH-1] && qn_i != q_i);
endmodule

bind piso_gated_shift piso_gated_shift_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op),
  .ser_i   (ser_s),
  .par_i   (par_i),
  .stages_i(stages_o),
  .q_i     (q_o),
  .qn_i    (qn_o)
);

// File: tb/piso_gated_shift_test.sv
`timescale 1ns/1ps
module piso_gated_shift_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, inh = 1'b0, shld_n = 1'b1, ser = 1'b0;
  logic [W-1:0] par = '0;
  logic q, qn;
  logic [W-1:0] st;
  logic [W-1:0] exp_st = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  piso_gated_shift #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .inh_i(inh),
    .shld_ni(shld_n), .ser_i(ser), .par_i(par),
    .q_o(q), .qn_o(qn), .stages_o(st)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] e);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, e);
    end
  endtask

  task automatic chk_out(string tag);
    chk(tag, st, exp_st);
    chk({tag, " R7 q/qn"}, W'({q, qn}), W'({exp_st[W-1], ~exp_st[W-1]}));
  endtask

  // R2: load with clock/inhibit/serial activity during it
  task automatic do_load(logic [W-1:0] v);
    par = v; shld_n = 1'b0;
    step(2);
    sclk = 1'b1; inh = 1'b1; ser = ~ser;
    step(2);
    sclk = 1'b0; inh = 1'b0;
    step(2);
    shld_n = 1'b1;
    step(4);
    exp_st = v;
  endtask

  task automatic shift_clk(logic b);
    ser = b; sclk = 1'b1;
    step(4);
    exp_st = {exp_st[W-2:0], b};
    chk_out("R3 clock shift");
    sclk = 1'b0;
    step(3);
    chk_out("R6 hold after clock fall");
  endtask

  task automatic shift_inh(logic b);
    ser = b; inh = 1'b1;
    step(4);
    exp_st = {exp_st[W-2:0], b};
    chk_out("R4 inhibit shift");
    inh = 1'b0;
    step(3);
    chk_out("R6 hold after inhibit fall");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    step(1);
    par = 8'hFF; ser = 1'b1;
    step(2);
    exp_st = '0;
    chk_out("R1 reset");
    par = '0; ser = 1'b0;
    rst_ni = 1'b1;
    step(3);
    chk_out("R1 after release");

    // sweep all load patterns, 8 shifts each alternating source
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] p;
      p = W'(v) ^ 8'hA5;
      do_load(W'(v));
      chk_out("R2 load");
      for (int i = 0; i < W; i++) begin
        if (i % 2 == 0) shift_clk(p[i]);
        else            shift_inh(p[i]);
      end
    end

    // R2: follows par changes during load
    shld_n = 1'b0; par = 8'h3C;
    step(4); exp_st = 8'h3C; chk_out("R2 follow first");
    par = 8'hC3; ser = 1'b1; sclk = 1'b1;
    step(4); exp_st = 8'hC3; chk_out("R2 follow second");
    sclk = 1'b0; ser = 1'b0;
    // R8: edge during load, clock held high through release
    sclk = 1'b1; inh = 1'b1;
    step(3);
    shld_n = 1'b1;
    step(6);
    chk_out("R8 no shift on release with clock high");
    inh = 1'b0;
    step(4);
    chk_out("R8 no shift when inhibit falls");
    sclk = 1'b0;
    step(4);
    shift_clk(1'b0);
    chk_out("R8 new edge shifts");

    // R5: clock rising under high inhibit
    inh = 1'b1;
    step(4);
    exp_st = {exp_st[W-2:0], 1'b0};  // inhibit rise itself shifts (ser=0)
    chk_out("R4 inhibit rise");
    ser = 1'b1; sclk = 1'b1;
    step(5);
    chk_out("R5 clock rise while inhibited");
    inh = 1'b0;
    step(3);
    inh = 1'b1;
    step(5);
    chk_out("R5 inhibit rise while clock high");
    sclk = 1'b0;
    step(3);
    inh = 1'b0;
    step(4);
    chk_out("R6 hold after both fall");

    // R10: simultaneous rise
    ser = 1'b1; sclk = 1'b1; inh = 1'b1;
    step(5);
    exp_st = {exp_st[W-2:0], 1'b1};
    chk_out("R10 single shift on joint rise");
    sclk = 1'b0; inh = 1'b0;
    step(4);

    // R9: latency
    prev = exp_st;
    ser = 1'b0; sclk = 1'b1;
    step(2);
    chk("R9 unchanged after two edges", st, prev);
    step(1);
    exp_st = {prev[W-2:0], 1'b0};
    chk("R9 shifted on third edge", st, exp_st);
    sclk = 1'b0;
    step(4);
    chk_out("R6 idle hold");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule